// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block models the device side of a parallel flash memory's status reporting while an internal program or erase operation is running. It watches an asynchronous bus made of active-low chip enable, output enable and write enable strobes, a sector address and an 8-bit data byte. It brings those strobes into its clock domain and counts completed write pulses. Once a full command sequence is seen, it starts a timed busy window. Reads made during that window return status instead of array data. Bit 7 is a polling bit. Bit 6 is a toggle bit that inverts on every new read.

The unlock code decoding is reduced to a 2-bit command-kind input, which is sampled with every write pulse. The array holds one byte per sector. Per-sector protection bits and the program and erase durations are plain inputs. The fixed windows for fully protected operations are derived from the clock frequency parameter `CLK_MHZ`: about 1 µs for a program and about 400 µs for an erase. Every pin is a plain control or status pin. There is no streaming interface, so no back-pressure rules apply.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, busy and dout_en are 0 and every sector reads 8'hFF.
- R2: A write pulse is a period with both ce_n and we_n low, and it completes when either strobe rises. cmd_kind is encoded as 0 = reset, 1 = program, 2 = sector erase, 3 = chip erase. A program starts busy only on the 4th completed pulse, and a sector or chip erase only on the 6th.
- R3: While a program is busy, a read returns the complement of bit 7 of the programmed byte on bit 7 and zeros on bits 5..0.
- R4: While an erase is busy, bit 7 reads 0. After the erase, the erased sectors read 8'hFF, so bit 7 reads 1.
- R5: A read starts when ce_n and oe_n are both low after either was high. Each read start during busy inverts bit 6, and bit 6 is 0 after reset.
- R6: While not busy, a read returns the addressed sector's byte and the toggle bit stops changing.
- R7: A program to an unprotected sector is busy for exactly prog_cycles cycles. The sector then holds its old byte ANDed with the programmed byte.
- R8: A program to a protected sector is busy for exactly CLK_MHZ cycles, and the sector is unchanged.
- R9: A sector erase targets the sector addressed on the 6th pulse, and a chip erase targets all sectors. Protected sectors are skipped. The busy window lasts exactly erase_cycles cycles.
- R10: An erase whose targets are all protected is busy for exactly 400*CLK_MHZ cycles and changes no sector.
- R11: A write pulse with cmd_kind 0 abandons a partly entered sequence. Write pulses during busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | SECT_W | Sector address |
| din | input | 8 | Write data byte |
| cmd_kind | input | 2 | Command kind sampled on each write pulse |
| sect_prot | input | 2**SECT_W | Protection bit per sector |
| prog_cycles | input | CNT_W | Program busy duration in cycles |
| erase_cycles | input | CNT_W | Erase busy duration in cycles |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | High while a read is active (drive enable) |
| busy | output | 1 | Embedded operation in progress |

## Verification
The bench probes the pulse count one short of a full sequence. A design that started an operation too early would show busy after the 3rd or 5th pulse. It measures each busy window exactly for protected and unprotected programs, for a mixed chip erase and for an all-protected erase. A wrong duration source or a skipped protection check shows up as a length mismatch or as a changed protected sector. It tracks the toggle bit across reads that span several operations and idle periods. A toggle that moved outside busy, or failed to flip on each strobe, breaks the expected byte sequence. Finally, it enters an aborted sequence and issues writes during busy. A design that kept a stale pulse count or accepted commands while busy would start an extra operation or alter a sector.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    CMD_RESET      = 2'd0,
    CMD_PROG       = 2'd1,
    CMD_SECT_ERASE = 2'd2,
    CMD_CHIP_ERASE = 2'd3
  } cmd_e;

  localparam int PROG_PULSES  = 4;
  localparam int ERASE_PULSES = 6;
endpackage

// File: rtl/fsg_bus_sync.sv
module fsg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_active,
  output logic rd_start,
  output logic wr_end
);
  logic [2:0] strobe_s;  // {we, oe, ce} after synchronisation
  logic       rd_q, wr_q, wr_now;

  for (genvar g = 0; g < 3; g++) begin : g_sync
    logic [STAGES-1:0] sh;
    logic              raw;
    assign raw = (g == 0) ? ce_n : (g == 1) ? oe_n : we_n;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], raw};
    end
    assign strobe_s[g] = sh[STAGES-1];
  end

  assign rd_active = ~strobe_s[0] & ~strobe_s[1];
  assign wr_now    = ~strobe_s[0] & ~strobe_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_active;
      wr_q <= wr_now;
    end
  end

  assign rd_start = rd_active & ~rd_q;
  assign wr_end   = wr_q & ~wr_now;

  // R5
  rd_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);
  // R2
  wr_end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> !wr_end);
endmodule

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
  import fsg_pkg::*;
#(
  parameter int SECT_W   = 3,
  parameter int NUM_SECT = 8,
  parameter int CNT_W    = 32,
  parameter int CLK_MHZ  = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_end,
  input  logic [SECT_W-1:0]   addr,
  input  logic [7:0]          din,
  input  logic [1:0]          cmd_kind,
  input  logic [NUM_SECT-1:0] sect_prot,
  input  logic [CNT_W-1:0]    prog_cycles,
  input  logic [CNT_W-1:0]    erase_cycles,
  output logic                busy,
  output logic                op_is_prog,
  output logic [7:0]          op_data,
  output logic [NUM_SECT-1:0] op_mask,
  output logic                op_done
);
  localparam logic [CNT_W-1:0]    PROT_PROG_CYC  = CNT_W'(CLK_MHZ);
  localparam logic [CNT_W-1:0]    PROT_ERASE_CYC = CNT_W'(CLK_MHZ * 400);
  localparam logic [NUM_SECT-1:0] ONE_HOT0       = NUM_SECT'(1);

  cmd_e                cmd;
  logic [2:0]          pulse_cnt, pulses_needed;
  logic [CNT_W-1:0]    timer, dur_raw, dur;
  logic [NUM_SECT-1:0] sel_mask, live_mask, start_mask;
  logic                is_prog, prot_hit, start;

  always_comb begin
    cmd           = cmd_e'(cmd_kind);
    is_prog       = (cmd == CMD_PROG);
    pulses_needed = is_prog ? 3'(PROG_PULSES) : 3'(ERASE_PULSES);
    sel_mask      = (cmd == CMD_CHIP_ERASE) ? '1 : (ONE_HOT0 << addr);
    live_mask     = sel_mask & ~sect_prot;
    prot_hit      = is_prog ? sect_prot[addr] : (live_mask == '0);
    if (is_prog) dur_raw = prot_hit ? PROT_PROG_CYC  : prog_cycles;
    else         dur_raw = prot_hit ? PROT_ERASE_CYC : erase_cycles;
    dur        = (dur_raw == '0) ? CNT_W'(1) : dur_raw;
    start_mask = prot_hit ? '0 : (is_prog ? sel_mask : live_mask);
    start      = wr_end && !busy && (cmd != CMD_RESET) &&
                 (pulse_cnt + 3'd1 == pulses_needed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt  <= '0;
      busy       <= 1'b0;
      timer      <= '0;
      op_is_prog <= 1'b0;
      op_data    <= '0;
      op_mask    <= '0;
      op_done    <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (wr_end && !busy) begin
        if (cmd == CMD_RESET || start) pulse_cnt <= '0;
        else                           pulse_cnt <= pulse_cnt + 3'd1;
      end
      if (start) begin
        busy       <= 1'b1;
        timer      <= dur - CNT_W'(1);
        op_is_prog <= is_prog;
        op_data    <= din;
        op_mask    <= start_mask;
      end else if (busy) begin
        if (timer == '0) begin
          busy    <= 1'b0;
          op_done <= 1'b1;
        end else begin
          timer <= timer - CNT_W'(1);
        end
      end
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_end));
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && timer == '0) |=> (!busy && op_done));
  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && timer != '0) |=> busy);
endmodule

// File: rtl/fsg_status_out.sv
module fsg_status_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       rd_start,
  input  logic       rd_active,
  input  logic       op_is_prog,
  input  logic       op_bit7,
  input  logic [7:0] cell_q,
  output logic [7:0] dout,
  output logic       dout_en
);
  logic tog;
  logic poll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tog <= 1'b0;
    else if (busy && rd_start) tog <= ~tog;
  end

  assign poll    = op_is_prog ? ~op_bit7 : 1'b0;
  assign dout    = busy ? {poll, tog, 6'b0} : cell_q;
  assign dout_en = rd_active;

  // R5
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (tog != $past(tog)));
  // R6
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !rd_start) |=> $stable(tog));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int SECT_W   = 3,
  parameter int CNT_W    = 32,
  parameter int CLK_MHZ  = 200,
  parameter int SYNC_STG = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [SECT_W-1:0]      addr,
  input  logic [7:0]             din,
  input  logic [1:0]             cmd_kind,
  input  logic [(2**SECT_W)-1:0] sect_prot,
  input  logic [CNT_W-1:0]       prog_cycles,
  input  logic [CNT_W-1:0]       erase_cycles,
  output logic [7:0]             dout,
  output logic                   dout_en,
  output logic                   busy
);
  localparam int NUM_SECT = 2 ** SECT_W;

  logic                     rd_active, rd_start, wr_end;
  logic                     op_is_prog, op_done;
  logic [7:0]               op_data;
  logic [NUM_SECT-1:0]      op_mask;
  logic [NUM_SECT-1:0][7:0] cells;

  fsg_bus_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_active(rd_active), .rd_start(rd_start), .wr_end(wr_end)
  );

  fsg_op_ctrl #(
    .SECT_W(SECT_W), .NUM_SECT(NUM_SECT), .CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .addr(addr), .din(din),
    .cmd_kind(cmd_kind), .sect_prot(sect_prot), .prog_cycles(prog_cycles),
    .erase_cycles(erase_cycles), .busy(busy), .op_is_prog(op_is_prog),
    .op_data(op_data), .op_mask(op_mask), .op_done(op_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '1;
    end else if (op_done) begin
      for (int i = 0; i < NUM_SECT; i++) begin
        if (op_mask[i]) cells[i] <= op_is_prog ? (cells[i] & op_data) : 8'hFF;
      end
    end
  end

  fsg_status_out u_out (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_start(rd_start),
    .rd_active(rd_active), .op_is_prog(op_is_prog), .op_bit7(op_data[7]),
    .cell_q(cells[addr]), .dout(dout), .dout_en(dout_en)
  );

  // R8
  array_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> $stable(cells));
  // R10
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cells));
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int SECT_W = 3;
  localparam int CNT_W  = 32;
  localparam int MHZ    = 20;
  localparam int NSECT  = 2 ** SECT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [SECT_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [1:0] cmd_kind = '0;
  logic [NSECT-1:0] sect_prot = '0;
  logic [CNT_W-1:0] prog_cycles = 32'd300, erase_cycles = 32'd400;
  logic [7:0] dout;
  logic dout_en, busy;

  int checks = 0, errors = 0;
  int run_len = 0, last_len = 0;
  logic tgl = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event smp_ev;

  flash_status_gen #(.SECT_W(SECT_W), .CNT_W(CNT_W), .CLK_MHZ(MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .cmd_kind(cmd_kind), .sect_prot(sect_prot),
    .prog_cycles(prog_cycles), .erase_cycles(erase_cycles),
    .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design drives them
  initial forever begin
    @(smp_ev);
    if (exp_q.size() != 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, {dout_en, dout}, {1'b1, e});
    end
  end

  // busy window length monitor
  always @(negedge clk) begin
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
  end

  task automatic bus_write(input logic [SECT_W-1:0] a, input logic [7:0] d, input logic [1:0] k);
    @(negedge clk);
    addr = a; din = d; cmd_kind = k; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input logic [SECT_W-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
    repeat (6) @(negedge clk);
    ->smp_ev;
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // status read during busy: driver computes the expected toggle
  task automatic busy_read(input logic [SECT_W-1:0] a, input logic b7, input string tag);
    tgl = ~tgl;
    bus_read(a, {b7, tgl, 6'b0}, tag);
  endtask

  task automatic prog_seq(input logic [SECT_W-1:0] a, input logic [7:0] d);
    for (int i = 0; i < 4; i++) bus_write(a, d, 2'd1);
  endtask

  task automatic erase_seq(input logic [SECT_W-1:0] a, input logic [1:0] k);
    for (int i = 0; i < 6; i++) bus_write(a, 8'h30, k);
  endtask

  task automatic wait_idle(input string tag, input int exp_len);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(tag, last_len, exp_len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 dout_en after reset", dout_en, 0);
    bus_read(3'd0, 8'hFF, "R1 sector 0 erased at reset");

    // program with bit7 = 0; check pulse count boundary
    for (int i = 0; i < 3; i++) bus_write(3'd2, 8'h5A, 2'd1);
    chk("R2 no busy after 3rd program pulse", busy, 0);
    bus_write(3'd2, 8'h5A, 2'd1);
    chk("R2 busy after 4th program pulse", busy, 1);
    busy_read(3'd2, 1'b1, "R3 program poll 1 / R5 toggle");
    busy_read(3'd2, 1'b1, "R5 toggle second read");
    busy_read(3'd2, 1'b1, "R5 toggle third read");
    wait_idle("R7 program busy length", 300);
    bus_read(3'd2, 8'h5A, "R7 programmed data");
    bus_read(3'd2, 8'h5A, "R6 toggle stopped idle read 1");
    bus_read(3'd2, 8'h5A, "R6 toggle stopped idle read 2");

    // program with bit7 = 1
    prog_seq(3'd3, 8'hA5);
    busy_read(3'd3, 1'b0, "R3 program poll 0");
    busy_read(3'd3, 1'b0, "R5 toggle after idle reads");
    wait_idle("R7 second program length", 300);
    bus_read(3'd3, 8'hA5, "R7 second programmed data");

    // protected program
    sect_prot = 8'b0010_0000;
    prog_seq(3'd5, 8'h00);
    busy_read(3'd5, 1'b1, "R8 protected program status");
    wait_idle("R8 protected program length", MHZ);
    bus_read(3'd5, 8'hFF, "R8 protected sector unchanged");

    // sector erase, boundary at 5 pulses
    for (int i = 0; i < 5; i++) bus_write(3'd2, 8'h30, 2'd2);
    chk("R2 no busy after 5th erase pulse", busy, 0);
    bus_write(3'd2, 8'h30, 2'd2);
    chk("R2 busy after 6th erase pulse", busy, 1);
    busy_read(3'd2, 1'b0, "R4 erase poll 0");
    wait_idle("R9 sector erase length", 400);
    bus_read(3'd2, 8'hFF, "R4 erased sector reads FF");
    bus_read(3'd3, 8'hA5, "R9 untargeted sector kept");

    // chip erase skipping a protected sector
    sect_prot = '0;
    prog_seq(3'd5, 8'h33);
    wait_idle("R7 program before chip erase", 300);
    sect_prot = 8'b0010_0000;
    erase_seq(3'd0, 2'd3);
    busy_read(3'd0, 1'b0, "R4 chip erase poll 0");
    wait_idle("R9 chip erase length", 400);
    bus_read(3'd3, 8'hFF, "R9 chip erase cleared sector 3");
    bus_read(3'd5, 8'h33, "R9 protected sector skipped");

    // erase whose only target is protected
    erase_seq(3'd5, 2'd2);
    busy_read(3'd5, 1'b0, "R10 all-protected erase status");
    wait_idle("R10 all-protected erase length", 400 * MHZ);
    bus_read(3'd5, 8'h33, "R10 no sector altered");

    // abort by reset command, then writes during busy
    for (int i = 0; i < 3; i++) bus_write(3'd6, 8'h0F, 2'd1);
    bus_write(3'd6, 8'h0F, 2'd0);
    for (int i = 0; i < 3; i++) bus_write(3'd6, 8'h0F, 2'd1);
    chk("R11 aborted sequence not started", busy, 0);
    bus_write(3'd6, 8'h0F, 2'd1);
    chk("R11 restart counted from abort", busy, 1);
    prog_seq(3'd1, 8'h00);
    wait_idle("R11 writes in busy do not extend", 300);
    chk("R11 no second op after busy writes", busy, 0);
    bus_read(3'd1, 8'hFF, "R11 busy writes ignored");
    bus_read(3'd6, 8'h0F, "R7 sector 6 programmed");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule